// File: doc/BRIEF.md
# Masked Vector Lane Extract Unit

This unit copies one aligned slice of a wide source vector into the bottom of a destination vector. The source is 256 or 512 bits wide. The slice is 128 or 256 bits wide and is chosen by the low bits of an immediate byte. Five operation codes select the slice width and the element view:

| Code | Slice width | Element size | Masked |
|------|-------------|--------------|--------|
| 0 | 128 bits | 32 bits | no |
| 1 | 128 bits | 32 bits | yes |
| 2 | 128 bits | 64 bits | yes |
| 3 | 256 bits | 32 bits | yes |
| 4 | 256 bits | 64 bits | yes |

The four masked codes pass each result element through a writemask. A masked-off element either takes the old destination bits (merging) or becomes zero (zeroing).

The unit also checks two encoding rules, described in R9 and R10. An encoding that breaks either rule raises a fault, and the data result is suppressed. One input strobe gives one registered output strobe on the next cycle.

Top module: `vec_lane_extract`

## Requirements
- R1: Codes 1 and 2 with a 256-bit source (`src_wide`=0), and code 0 in all cases, take the 128-bit slice at bit offset imm[0]*128. Code 0 always treats the source as 256 bits and ignores `src_wide`.
- R2: Codes 1 and 2 with a 512-bit source (`src_wide`=1) take the 128-bit slice at bit offset imm[1:0]*128.
- R3: Codes 3 and 4 take the 256-bit half at bit offset imm[0]*256. These codes require a 512-bit source; with `src_wide`=0 they raise the fault.
- R4: Immediate bits above the index bits that the code uses have no effect on the result. Those are bits 7:1, or bits 7:2 for codes 1 and 2 with a 512-bit source.
- R5: Code 1 masks per 32-bit element with mask[3:0]. Code 3 masks per 32-bit element with mask[7:0]. Bit i governs result bits 32i+31:32i.
- R6: Code 2 masks per 64-bit element with mask[1:0]. Code 4 masks per 64-bit element with mask[3:0]. Bit i governs result bits 64i+63:64i.
- R7: A masked-off element takes the same bits of `old_dst` when `zero_mode`=0, and becomes zero when `zero_mode`=1. Code 0 ignores both the mask and `zero_mode`.
- R8: All output bits above the slice width (128 or 256) are zero.
- R9: If `reg_spec` is not 4'b1111, or the code is 5, 6 or 7, then `out_fault`=1 and `out_data` is zero.
- R10: Code 0 with `vec_len`=0 raises the fault and gives zero data. `vec_len` has no effect on codes 1 to 4.
- R11: After reset, `out_valid`, `out_fault` and `out_data` are zero. `in_valid` in cycle n gives `out_valid`=1 in cycle n+1 only. The output data and fault stay unchanged until the next strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation strobe |
| op | input | 3 | Operation code (0 to 4; see the table above) |
| src_wide | input | 1 | 1 = 512-bit source, 0 = 256-bit source |
| vec_len | input | 1 | Vector-length bit, checked for code 0 only |
| reg_spec | input | 4 | Reserved register specifier; must be 4'b1111 |
| zero_mode | input | 1 | 1 = zeroing, 0 = merging |
| imm | input | 8 | Immediate byte |
| mask | input | 8 | Element writemask |
| src | input | 512 | Source vector |
| old_dst | input | 512 | Previous destination value |
| out_valid | output | 1 | Result strobe |
| out_fault | output | 1 | Illegal-encoding fault |
| out_data | output | 512 | Result vector |

## Verification
A wrong lane index shows up on the very next strobe: the whole low slice of `out_data` then carries words from the wrong source lane. Each source word is unique, so the wrong offset can be read straight from the mismatch.

A mask bit applied to the wrong element, or merge and zero swapped, corrupts only the affected elements. For that reason, the stimulus mixes sparse and dense masks in both modes.

A fault decision that is wrong shows up in the same output cycle, either as `out_fault` or as non-zero data where zero is expected. Stale contents in the output register show up when `out_data` changes between strobes.

// File: rtl/vec_lane_extract.sv
module vec_lane_extract #(
  parameter int VEC_W  = 512,
  parameter int LANE_W = 128,
  parameter int WORD_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [2:0]       op,
  input  logic             src_wide,
  input  logic             vec_len,
  input  logic [3:0]       reg_spec,
  input  logic             zero_mode,
  input  logic [7:0]       imm,
  input  logic [7:0]       mask,
  input  logic [VEC_W-1:0] src,
  input  logic [VEC_W-1:0] old_dst,
  output logic             out_valid,
  output logic             out_fault,
  output logic [VEC_W-1:0] out_data
);
  localparam int NWORDS = VEC_W / WORD_W;
  localparam int LWORDS = LANE_W / WORD_W;
  localparam int HWORDS = 2 * LWORDS;

  localparam logic [2:0] OP_PLAIN = 3'd0;
  localparam logic [2:0] OP_S4    = 3'd1;
  localparam logic [2:0] OP_D2    = 3'd2;
  localparam logic [2:0] OP_S8    = 3'd3;
  localparam logic [2:0] OP_D4    = 3'd4;

  logic             half_res;
  logic             dbl_view;
  logic             masked;
  logic             bad;
  logic [1:0]       lane_idx;
  logic [VEC_W-1:0] shifted;
  logic [VEC_W-1:0] merged;

  assign half_res = (op == OP_S8) || (op == OP_D4);
  assign dbl_view = (op == OP_D2) || (op == OP_D4);
  assign masked   = (op != OP_PLAIN);

  assign bad = (reg_spec != 4'hF) || (op > OP_D4) ||
               ((op == OP_PLAIN) && !vec_len) ||
               (half_res && !src_wide);

  always_comb begin
    if (half_res)
      lane_idx = {imm[0], 1'b0};
    else if (masked && src_wide)
      lane_idx = imm[1:0];
    else
      lane_idx = {1'b0, imm[0]};
  end

  assign shifted = src >> (lane_idx * LANE_W);

  genvar w;
  generate
    for (w = 0; w < NWORDS; w++) begin : g_word
      if (w < HWORDS) begin : g_live
        logic in_res;
        logic mbit;
        assign in_res = (w < LWORDS) || half_res;
        assign mbit   = !masked || (dbl_view ? mask[w/2] : mask[w]);
        assign merged[w*WORD_W +: WORD_W] =
          !in_res  ? '0 :
          mbit     ? shifted[w*WORD_W +: WORD_W] :
          zero_mode ? '0 : old_dst[w*WORD_W +: WORD_W];
      end else begin : g_dead
        assign merged[w*WORD_W +: WORD_W] = '0;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_fault <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_fault <= bad;
        out_data  <= bad ? '0 : merged;
      end
    end
  end

  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid) else $error("latency"); // R11
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && $stable(out_data) && $stable(out_fault)) else $error("spurious"); // R11
  AST_FAULT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    out_fault |-> out_data == '0) else $error("fault data"); // R9
  AST_SPEC_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && reg_spec != 4'hF |=> out_fault) else $error("spec"); // R9
  AST_PLAIN_VL: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op == OP_PLAIN && !vec_len |=> out_fault) else $error("vl"); // R10
  AST_UPPER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_data[VEC_W-1:2*LANE_W] == '0) else $error("upper"); // R8
  AST_NARROW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op <= OP_D2 |=> out_data[2*LANE_W-1:LANE_W] == '0) else $error("narrow"); // R8
endmodule

// File: tb/vec_lane_extract_tb.sv
module vec_lane_extract_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [2:0]   op = '0;
  logic         src_wide = 1'b0;
  logic         vec_len = 1'b1;
  logic [3:0]   reg_spec = 4'hF;
  logic         zero_mode = 1'b0;
  logic [7:0]   imm = '0;
  logic [7:0]   mask = '0;
  logic [511:0] src, old_dst;
  logic         out_valid, out_fault;
  logic [511:0] out_data;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  vec_lane_extract dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .src_wide(src_wide),
    .vec_len(vec_len), .reg_spec(reg_spec), .zero_mode(zero_mode), .imm(imm),
    .mask(mask), .src(src), .old_dst(old_dst), .out_valid(out_valid),
    .out_fault(out_fault), .out_data(out_data));

  task automatic chk(string tag, logic [511:0] act, logic [511:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [511:0] model(logic [2:0] o, logic w, logic [7:0] im,
                                         logic [7:0] m, logic z);
    logic [511:0] r = '0;
    int nbits = (o >= 3) ? 256 : 128;
    int esz = (o == 2 || o == 4) ? 64 : 32;
    int base;
    if (o >= 3) base = im[0] * 256;
    else if (o != 0 && w) base = im[1:0] * 128;
    else base = im[0] * 128;
    for (int e = 0; e < nbits / esz; e++) begin
      bit on = (o == 0) || m[e];
      for (int b = 0; b < esz; b++)
        r[e*esz+b] = on ? src[base+e*esz+b] : (z ? 1'b0 : old_dst[e*esz+b]);
    end
    return r;
  endfunction

  task automatic run(logic [2:0] o, logic w, logic vl, logic [3:0] sp,
                     logic [7:0] im, logic [7:0] m, logic z);
    @(negedge clk);
    op = o; src_wide = w; vec_len = vl; reg_spec = sp; imm = im; mask = m;
    zero_mode = z; in_valid = 1'b1;
    @(posedge clk); #1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic expect_ok(string tag, logic [2:0] o, logic w, logic [7:0] im,
                           logic [7:0] m, logic z);
    run(o, w, 1'b1, 4'hF, im, m, z);
    chk({tag, " valid"}, {511'd0, out_valid}, 512'd1);
    chk({tag, " fault"}, {511'd0, out_fault}, 512'd0);
    chk({tag, " data"}, out_data, model(o, w, im, m, z));
  endtask

  task automatic expect_fault(string tag, logic [2:0] o, logic w, logic vl, logic [3:0] sp);
    run(o, w, vl, sp, 8'h01, 8'hFF, 1'b0);
    chk({tag, " fault"}, {511'd0, out_fault}, 512'd1);
    chk({tag, " data"}, out_data, 512'd0);
  endtask

  task automatic t_reset;
    chk("R11 reset valid", {511'd0, out_valid}, 512'd0);
    chk("R11 reset fault", {511'd0, out_fault}, 512'd0);
    chk("R11 reset data", out_data, 512'd0);
  endtask

  task automatic t_lane256;
    for (int i = 0; i < 2; i++) begin
      expect_ok("R1 plain", 3'd0, 1'b0, 8'(i), 8'h00, 1'b1);
      expect_ok("R1 s4 narrow", 3'd1, 1'b0, 8'(i), 8'h0F, 1'b0);
      expect_ok("R1 d2 narrow", 3'd2, 1'b0, 8'(i), 8'h03, 1'b0);
    end
    expect_ok("R1 plain ignores src_wide", 3'd0, 1'b1, 8'h01, 8'h00, 1'b0);
  endtask

  task automatic t_lane512;
    for (int i = 0; i < 4; i++) begin
      expect_ok("R2 s4 wide", 3'd1, 1'b1, 8'(i), 8'h0F, 1'b0);
      expect_ok("R2 d2 wide", 3'd2, 1'b1, 8'(i), 8'h03, 1'b1);
    end
  endtask

  task automatic t_half;
    for (int i = 0; i < 2; i++) begin
      expect_ok("R3 s8", 3'd3, 1'b1, 8'(i), 8'hFF, 1'b0);
      expect_ok("R3 d4", 3'd4, 1'b1, 8'(i), 8'h0F, 1'b0);
    end
    expect_fault("R3 narrow source", 3'd3, 1'b0, 1'b1, 4'hF);
  endtask

  task automatic t_imm_high;
    expect_ok("R4 s4 wide high", 3'd1, 1'b1, 8'hFE, 8'h0F, 1'b0);
    expect_ok("R4 d4 high", 3'd4, 1'b1, 8'hAB, 8'h0F, 1'b0);
    expect_ok("R4 plain high", 3'd0, 1'b0, 8'hF0, 8'h00, 1'b0);
  endtask

  task automatic t_mask32;
    expect_ok("R5 s4 sparse", 3'd1, 1'b1, 8'h02, 8'b0101, 1'b0);
    expect_ok("R5 s8 sparse", 3'd3, 1'b1, 8'h01, 8'b1001_0110, 1'b0);
    expect_ok("R5 s4 ignores mask high", 3'd1, 1'b0, 8'h01, 8'hF2, 1'b0);
  endtask

  task automatic t_mask64;
    expect_ok("R6 d2 one", 3'd2, 1'b1, 8'h03, 8'b10, 1'b0);
    expect_ok("R6 d4 sparse", 3'd4, 1'b1, 8'h00, 8'b0110, 1'b0);
  endtask

  task automatic t_merge_zero;
    expect_ok("R7 merge", 3'd3, 1'b1, 8'h00, 8'h3C, 1'b0);
    expect_ok("R7 zero", 3'd3, 1'b1, 8'h00, 8'h3C, 1'b1);
    expect_ok("R7 plain ignores mask", 3'd0, 1'b0, 8'h00, 8'h00, 1'b0);
  endtask

  task automatic t_upper;
    expect_ok("R8 narrow", 3'd1, 1'b1, 8'h03, 8'h00, 1'b0);
    chk("R8 bits above 128", {128'd0, out_data[511:128]}, 512'd0);
  endtask

  task automatic t_spec;
    expect_fault("R9 spec", 3'd1, 1'b1, 1'b1, 4'hE);
    expect_fault("R9 spec zero", 3'd4, 1'b1, 1'b1, 4'h0);
    expect_fault("R9 op5", 3'd5, 1'b1, 1'b1, 4'hF);
    expect_fault("R9 op7", 3'd7, 1'b1, 1'b1, 4'hF);
  endtask

  task automatic t_legacy;
    expect_fault("R10 plain vl0", 3'd0, 1'b0, 1'b0, 4'hF);
    run(3'd2, 1'b1, 1'b0, 4'hF, 8'h01, 8'h01, 1'b0);
    chk("R10 masked vl0 fault", {511'd0, out_fault}, 512'd0);
    chk("R10 masked vl0 data", out_data, model(3'd2, 1'b1, 8'h01, 8'h01, 1'b0));
  endtask

  task automatic t_hold;
    logic [511:0] keep;
    expect_ok("R11 seed", 3'd4, 1'b1, 8'h01, 8'h05, 1'b0);
    keep = out_data;
    @(negedge clk);
    src = ~src;
    @(posedge clk); #1;
    chk("R11 no strobe", {511'd0, out_valid}, 512'd0);
    chk("R11 hold data", out_data, keep);
    src = ~src;
  endtask

  initial begin
    for (int k = 0; k < 16; k++) begin
      src[k*32 +: 32]     = {8'hA5, 8'(k), 16'h3C00 + 16'(k * 7)};
      old_dst[k*32 +: 32] = {8'hD0, 8'(k), 16'hBEEF};
    end
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_lane256();
    t_lane512();
    t_half();
    t_imm_high();
    t_mask32();
    t_mask64();
    t_merge_zero();
    t_upper();
    t_spec();
    t_legacy();
    t_hold();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule